// File: doc/BRIEF.md
# Serial ADC Output Framer

This block is the digital face of a sampling converter that reports its results over a serial line. A host drives an active-low chip select and a serial clock. The block runs on a faster system clock and oversamples both host signals. When chip select falls, it captures the parallel sample word on its input and goes into hold. It then sends a 16-bit frame, moving one bit on each serial clock falling edge. Between frames the data line is released. The data line is modelled as a value plus an output-enable, so that the released intervals can be seen.

The frame has two layouts. In full-width mode, four zero bits come first, followed by the 12-bit sample, most significant bit first. In narrow mode, four zero bits come first, followed by the ten most significant sample bits, then two zero bits. The sample is taken as a two's complement word and is passed through unchanged. A hold indicator shows when the converter is in hold. It returns to track partway through the frame. If chip select rises early, the frame is abandoned.

Top module: `sadc_framer`

## Requirements
- R1: While reset is high and after it is released, with no frame started, `sdata_oe_o`, `sdata_o` and `hold_o` are all 0.
- R2: Each host edge goes through a synchroniser of SYNC_STAGES flops (default 2). The outputs respond at the (SYNC_STAGES+1)th rising `clk` edge after the input changes.
- R3: A chip-select fall sets `sdata_oe_o` to 1 and `hold_o` to 1, and drives `sdata_o` to 0, the first leading zero. In the same cycle it captures `sample_i` and `narrow_i`.
- R4: While a frame is active, each serial clock fall moves to the next frame bit. A serial clock rise never changes `sdata_o`.
- R5: With `narrow_i`=0 captured, frame bits 0..3 are 0 and frame bits 4..15 are `sample_i[11]` down to `sample_i[0]`. Frame bit k is on the line after the kth serial clock fall, and bit 0 is on the line right after chip select falls.
- R6: With `narrow_i`=1 captured, frame bits 0..3 are 0, frame bits 4..13 are `sample_i[11]` down to `sample_i[2]`, and frame bits 14..15 are 0.
- R7: `hold_o` returns to 0 at the first serial clock rise that follows the 13th serial clock fall of the frame.
- R8: At the 16th serial clock fall, `sdata_oe_o` drops to 0. Further serial clock edges have no effect until chip select rises and then falls again.
- R9: If chip select rises before the 16th fall, `sdata_oe_o` and `hold_o` drop to 0 on that update.
- R10: A change of `sample_i` or `narrow_i` after the chip-select fall does not alter the frame being sent.
- R11: Whenever `sdata_oe_o` is 0, `sdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the host signals |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Host chip select, active low |
| sclk_i | input | 1 | Host serial clock, idles high |
| sample_i | input | DATA_W | Parallel two's complement sample word |
| narrow_i | input | 1 | 1 selects the ten-bit frame layout |
| sdata_o | output | 1 | Serial data value |
| sdata_oe_o | output | 1 | Output enable for the serial data line |
| hold_o | output | 1 | 1 while in hold, 0 while tracking |

## Verification
The checker tests on every cycle the relations between the three outputs. The data value stays 0 while the line is released. A new frame opens on a zero bit, and hold can only start together with a new frame. Hold only ends while the line is driven or at the moment it is released, and it is always low once the line is released. Only the bench scenarios can show that the bit order is right for each mode, that the frame is immune to sample changes, that the release point falls on the 13th edge, and that the synchroniser latency is correct. For this, the bench compares against a delayed-input reference model on every clock and makes targeted checks for each frame position.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic {
    LAYOUT_FULL   = 1'b0,
    LAYOUT_NARROW = 1'b1
  } layout_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/sadc_edge_sync.sv
module sadc_edge_sync #(
  parameter int   STAGES     = 2,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pin_i,
  output sadc_pkg::edge_t edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= IDLE_LEVEL;
        else     chain_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= IDLE_LEVEL;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IDLE_LEVEL;
    else     last_q <= chain_q[STAGES-1];
  end

  always_comb begin
    edge_o.fall = last_q & ~chain_q[STAGES-1];
    edge_o.rise = ~last_q & chain_q[STAGES-1];
  end
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl #(
  parameter int FRAME_LEN    = 16,
  parameter int RELEASE_EDGE = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  sadc_pkg::edge_t cs_edge_i,
  input  sadc_pkg::edge_t sclk_edge_i,
  output logic            load_o,
  output logic            shift_o,
  output logic            clear_o,
  output logic            oe_o,
  output logic            hold_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;
  logic             finish;
  logic             release_pt;

  // chip select fall opens a frame, a rise closes it whatever the count
  always_comb begin
    cnt_nxt    = cnt_q + 1'b1;
    step       = active_q && sclk_edge_i.fall && !cs_edge_i.fall && !cs_edge_i.rise;
    finish     = step && (cnt_nxt == CNT_W'(FRAME_LEN));
    release_pt = active_q && sclk_edge_i.rise && !cs_edge_i.rise
                 && (cnt_q >= CNT_W'(RELEASE_EDGE));
    load_o     = cs_edge_i.fall;
    shift_o    = step && !finish;
    clear_o    = cs_edge_i.rise || finish;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      oe_o     <= 1'b0;
      hold_o   <= 1'b0;
    end else if (cs_edge_i.rise) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      oe_o     <= 1'b0;
      hold_o   <= 1'b0;
    end else if (load_o) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      oe_o     <= 1'b1;
      hold_o   <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_nxt;
      if (finish) begin
        active_q <= 1'b0;
        oe_o     <= 1'b0;
      end
    end else if (release_pt) begin
      hold_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sadc_shift_out.sv
module sadc_shift_out #(
  parameter int DATA_W     = 12,
  parameter int NARROW_W   = 10,
  parameter int LEAD_ZEROS = 4,
  parameter int FRAME_LEN  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] sample_i,
  input  sadc_pkg::layout_e layout_i,
  output logic              data_o
);
  localparam int TOP = FRAME_LEN - 1 - LEAD_ZEROS;

  logic [FRAME_LEN-1:0] frame_w;
  logic [FRAME_LEN-1:0] buf_q;

  // place the captured word after the leading zeros, MSB first
  always_comb begin
    frame_w = '0;
    if (layout_i == sadc_pkg::LAYOUT_NARROW) begin
      for (int i = 0; i < NARROW_W; i++)
        frame_w[TOP-i] = sample_i[DATA_W-1-i];
    end else begin
      for (int i = 0; i < DATA_W; i++)
        frame_w[TOP-i] = sample_i[DATA_W-1-i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q  <= '0;
      data_o <= 1'b0;
    end else if (clear_i) begin
      buf_q  <= '0;
      data_o <= 1'b0;
    end else if (load_i) begin
      data_o <= frame_w[FRAME_LEN-1];
      buf_q  <= {frame_w[FRAME_LEN-2:0], 1'b0};
    end else if (shift_i) begin
      data_o <= buf_q[FRAME_LEN-1];
      buf_q  <= {buf_q[FRAME_LEN-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/sadc_framer.sv
module sadc_framer #(
  parameter int DATA_W       = 12,
  parameter int NARROW_W     = 10,
  parameter int LEAD_ZEROS   = 4,
  parameter int FRAME_LEN    = 16,
  parameter int RELEASE_EDGE = 13,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              narrow_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              hold_o
);
  sadc_pkg::edge_t   cs_edge;
  sadc_pkg::edge_t   sclk_edge;
  sadc_pkg::layout_e layout;
  logic              load;
  logic              shift;
  logic              clear;

  assign layout = narrow_i ? sadc_pkg::LAYOUT_NARROW : sadc_pkg::LAYOUT_FULL;

  sadc_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .pin_i(cs_n_i), .edge_o(cs_edge)
  );

  sadc_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sclk_sync (
    .clk(clk), .rst(rst), .pin_i(sclk_i), .edge_o(sclk_edge)
  );

  sadc_frame_ctrl #(.FRAME_LEN(FRAME_LEN), .RELEASE_EDGE(RELEASE_EDGE)) u_ctrl (
    .clk(clk), .rst(rst), .cs_edge_i(cs_edge), .sclk_edge_i(sclk_edge),
    .load_o(load), .shift_o(shift), .clear_o(clear),
    .oe_o(sdata_oe_o), .hold_o(hold_o)
  );

  sadc_shift_out #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W),
    .LEAD_ZEROS(LEAD_ZEROS), .FRAME_LEN(FRAME_LEN)
  ) u_shift (
    .clk(clk), .rst(rst), .load_i(load), .shift_i(shift), .clear_i(clear),
    .sample_i(sample_i), .layout_i(layout), .data_o(sdata_o)
  );
endmodule

// File: rtl/sadc_framer_chk.sv
module sadc_framer_chk (
  input logic clk,
  input logic rst,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic hold_o
);
  p_idle_low_r11: assert property (@(posedge clk) disable iff (rst)
    !sdata_oe_o |-> !sdata_o);

  p_lead_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sdata_oe_o) |-> !sdata_o);

  p_hold_with_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_o) |-> $rose(sdata_oe_o));

  // covers both normal completion (R8) and abort (R9)
  p_track_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(sdata_oe_o) |-> !hold_o);

  p_release_framed_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_o) |-> (sdata_oe_o || $fell(sdata_oe_o)));
endmodule

bind sadc_framer sadc_framer_chk u_chk (
  .clk(clk), .rst(rst), .sdata_o(sdata_o),
  .sdata_oe_o(sdata_oe_o), .hold_o(hold_o)
);

// File: tb/sadc_framer_tb.sv
`timescale 1ns/100ps
module sadc_framer_tb;
  localparam int N    = 2;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] sample = '0;
  logic        narrow = 1'b0;
  logic        sdata, sdata_oe, hold;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sadc_framer #(.SYNC_STAGES(N)) u_dut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk),
    .sample_i(sample), .narrow_i(narrow),
    .sdata_o(sdata), .sdata_oe_o(sdata_oe), .hold_o(hold)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [11:0] s, input logic nar, input int k);
    if (k < 4) return 1'b0;
    if (nar) return (k < 14) ? s[15-k] : 1'b0;
    return s[15-k];
  endfunction

  // reference model: inputs delayed by N+1 edges, frame rules applied behaviourally
  logic q_cs[$];
  logic q_sc[$];
  bit   m_active, m_oe, m_hold, m_data;
  int   m_cnt;
  logic [15:0] m_word;

  always @(posedge clk) begin
    if (rst) begin
      q_cs.delete(); q_sc.delete();
      for (int i = 0; i < N + 2; i++) begin q_cs.push_front(1'b1); q_sc.push_front(1'b1); end
      m_active = 0; m_oe = 0; m_hold = 0; m_data = 0; m_cnt = 0; m_word = '0;
    end else begin
      q_cs.push_front(cs_n); q_sc.push_front(sclk);
      void'(q_cs.pop_back()); void'(q_sc.pop_back());
      if (!q_cs[N+1] && q_cs[N]) begin
        m_active = 0; m_oe = 0; m_hold = 0; m_data = 0;
      end else if (q_cs[N+1] && !q_cs[N]) begin
        for (int k = 0; k < 16; k++) m_word[15-k] = exp_bit(sample, narrow, k);
        m_active = 1; m_cnt = 0; m_oe = 1; m_hold = 1; m_data = m_word[15];
      end else if (m_active && q_sc[N+1] && !q_sc[N]) begin
        m_cnt++;
        if (m_cnt == 16) begin m_active = 0; m_oe = 0; m_data = 0; end
        else m_data = m_word[15-m_cnt];
      end else if (m_active && !q_sc[N+1] && q_sc[N] && m_cnt >= 13) begin
        m_hold = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(sdata_oe == m_oe, "R2 R3 R8 R9 model oe", sdata_oe, m_oe);
      check(hold == m_hold, "R7 model hold", hold, m_hold);
      check(sdata == m_data, "R4 R5 R6 model data", sdata, m_data);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // run one host frame with nf serial clock falls; optional mid-frame input change
  task automatic run_frame(input logic [11:0] s, input logic nar, input int nf,
                           input bit change, input logic [11:0] s2);
    logic prev;
    @(negedge clk);
    sample = s; narrow = nar; cs_n = 1'b0;
    wait_cyc(HALF);
    check(sdata_oe == 1 && hold == 1 && sdata == 0, "R3 frame start", {sdata_oe, hold, sdata}, 3'b110);
    for (int i = 1; i <= nf; i++) begin
      sclk = 1'b0;
      if (change && i == 3) begin sample = s2; narrow = ~nar; end
      wait_cyc(HALF);
      if (i < 16) begin
        check(sdata_oe == 1, "R8 line driven mid frame", sdata_oe, 1);
        check(sdata == exp_bit(s, nar, i), change ? "R10 captured word bit" :
              (nar ? "R6 narrow bit" : "R5 full bit"), sdata, exp_bit(s, nar, i));
      end else begin
        check(sdata_oe == 0 && sdata == 0, "R8 R11 released after last fall", {sdata_oe, sdata}, 0);
      end
      prev = sdata;
      sclk = 1'b1;
      wait_cyc(HALF);
      check(sdata == prev, "R4 rise keeps data", sdata, prev);
      if (i < 16) check(hold == (i < 13), "R7 hold release point", hold, (i < 13));
    end
    if (nf < 16) begin
      cs_n = 1'b1;
      wait_cyc(HALF);
      check(sdata_oe == 0 && hold == 0, "R9 abort", {sdata_oe, hold}, 0);
    end else begin
      for (int j = 0; j < 2; j++) begin
        sclk = 1'b0; wait_cyc(HALF);
        check(sdata_oe == 0 && sdata == 0 && hold == 0, "R8 extra clocks ignored", {sdata_oe, sdata, hold}, 0);
        sclk = 1'b1; wait_cyc(HALF);
      end
      cs_n = 1'b1;
    end
    wait_cyc(2 * HALF);
  endtask

  initial begin
    wait_cyc(5);
    check(sdata_oe == 0 && sdata == 0 && hold == 0, "R1 in reset", {sdata_oe, sdata, hold}, 0);
    rst = 1'b0;
    wait_cyc(4);
    check(sdata_oe == 0 && sdata == 0 && hold == 0, "R1 after reset", {sdata_oe, sdata, hold}, 0);

    // R2: response after exactly N+1 rising edges
    cs_n = 1'b0;
    wait_cyc(N);
    check(sdata_oe == 0, "R2 not yet", sdata_oe, 0);
    wait_cyc(1);
    check(sdata_oe == 1, "R2 latency", sdata_oe, 1);
    cs_n = 1'b1;
    wait_cyc(2 * HALF);

    run_frame(12'hA5C, 1'b0, 16, 0, '0);
    run_frame(12'h800, 1'b0, 16, 0, '0);
    run_frame(12'h7FF, 1'b0, 16, 0, '0);
    run_frame(12'hABF, 1'b1, 16, 0, '0);
    run_frame(12'h3C7, 1'b1, 16, 0, '0);
    run_frame(12'h5A3, 1'b0, 16, 1, 12'hFFF);
    run_frame(12'h9E1, 1'b1, 16, 1, 12'h000);
    run_frame(12'hFFF, 1'b0, 7, 0, '0);
    run_frame(12'h123, 1'b1, 14, 0, '0);
    run_frame(12'h6B4, 1'b0, 16, 0, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule